// File: doc/BRIEF.md
# Translation Fault Status Recorder

This block sits after an address translation unit and turns a failed lookup into an exception request. On each fault strobe it reads four inputs: the result code of the lookup (no match, protection violation, no-execute, direct-store), the kind of access (fetch, integer load/store, floating-point, reservation, external control), a store flag and the faulting effective address. From these it decides which exception to raise (instruction-storage, data-storage, alignment or program). It registers that exception type together with an error code, updates a fault status word and a fault address register, and pulses an exception request for one cycle.

Several rules shape the decoding. A store sets a separate indicator bit in the data status word. A direct-store fault on a floating-point access becomes an alignment exception. Any combination the block does not recognise falls back to a program exception, and the address is still captured in that case. Software can overwrite the status word or the address register through a simple write port.

Top module: `fault_recorder`

## Requirements
- R1: `exc_req` goes high in the cycle after `fault_valid` is sampled high, for exactly one cycle. It stays low when no strobe was sampled.
- R2: For a fetch (kind 0), the block raises type 0 (instruction-storage). The error code is 0x40000000 for no match (code 1), 0x08000000 for protection (code 2), and 0x10000000 for no-execute (code 3) or direct-store (code 4).
- R3: For a data access (kind 1..4), no match raises type 1 (data-storage) with error code 0 and status 0x40000000. A store adds bit 25, giving 0x42000000.
- R4: For a data access, a protection violation raises type 1 with status 0x08000000. A store gives 0x0A000000.
- R5: A direct-store fault on a reservation access (kind 3) raises type 1 with status 0x04000000. A store gives 0x06000000.
- R6: A direct-store fault on an external-control access (kind 4) raises type 1 with status 0x04100000. A store gives 0x06100000.
- R7: A direct-store fault on a floating-point access (kind 2) raises type 2 (alignment) with error code 0x00000010. The status word is left unchanged.
- R8: Every fault that is not a fetch fault loads the fault address register with `fault_addr`. Fetch faults of types 0 leave both the address and the status registers unchanged.
- R9: Every other combination raises type 3 (program) with error code 0x00000020 and captures the address. This covers result codes 0, 5, 6 and 7, kinds 5..7, data no-execute, and direct-store on an integer access (kind 1). The status word is unchanged.
- R10: The status and address registers hold their values between events. `sw_we` writes `sw_wdata` into the status word when `sw_sel`=0 and into the address register when `sw_sel`=1. A fault strobe in the same cycle takes priority over the write. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | Fault strobe |
| result_code | input | 3 | Translation result code |
| access_kind | input | 3 | Access kind |
| is_store | input | 1 | Access is a store |
| fault_addr | input | ADDR_W | Faulting effective address |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | 1 | Write target: 0 status, 1 address |
| sw_wdata | input | 32 | Software write data |
| exc_req | output | 1 | One-cycle exception request |
| exc_type | output | 2 | Registered exception type |
| err_code | output | 32 | Registered error code |
| fault_status | output | 32 | Fault status word |
| fault_addr_q | output | ADDR_W | Fault address register |

## Verification
The assertions assume that `result_code`, `access_kind` and `is_store` are stable and meaningful whenever `fault_valid` is sampled. They also assume that a strobe sampled with a software write always takes precedence. The bench drives inputs only at falling edges and sweeps all 128 combinations of code, kind and store flag. Before each fault it loads distinct marker values into both registers through the write port, so that an untouched register can be seen at the ports. It also exercises a strobe that collides with a write.

// File: rtl/fault_recorder_pkg.sv
package fault_recorder_pkg;
  localparam int STAT_W = 32;

  localparam logic [2:0] RC_NOMATCH = 3'd1;
  localparam logic [2:0] RC_PROT    = 3'd2;
  localparam logic [2:0] RC_NOEXEC  = 3'd3;
  localparam logic [2:0] RC_DIRECT  = 3'd4;

  localparam logic [2:0] AK_FETCH   = 3'd0;
  localparam logic [2:0] AK_INT     = 3'd1;
  localparam logic [2:0] AK_FP      = 3'd2;
  localparam logic [2:0] AK_RESV    = 3'd3;
  localparam logic [2:0] AK_EXTCTL  = 3'd4;

  typedef enum logic [1:0] {
    EXC_ISTORAGE = 2'd0,
    EXC_DSTORAGE = 2'd1,
    EXC_ALIGN    = 2'd2,
    EXC_PROGRAM  = 2'd3
  } exc_kind_e;

  localparam logic [STAT_W-1:0] ISI_NOMATCH  = 32'h4000_0000;
  localparam logic [STAT_W-1:0] ISI_PROT     = 32'h0800_0000;
  localparam logic [STAT_W-1:0] ISI_NOEXEC   = 32'h1000_0000;
  localparam logic [STAT_W-1:0] DST_NOMATCH  = 32'h4000_0000;
  localparam logic [STAT_W-1:0] DST_PROT     = 32'h0800_0000;
  localparam logic [STAT_W-1:0] DST_RESV     = 32'h0400_0000;
  localparam logic [STAT_W-1:0] DST_EXTCTL   = 32'h0410_0000;
  localparam int                STORE_BIT    = 25;
  localparam logic [STAT_W-1:0] ALIGN_FP_SUB = 32'h0000_0010;
  localparam logic [STAT_W-1:0] PROG_INVALID = 32'h0000_0020;

  typedef struct packed {
    exc_kind_e         kind;
    logic [STAT_W-1:0] code;
    logic [STAT_W-1:0] status;
    logic              upd_status;
    logic              upd_addr;
  } fault_decision_t;
endpackage

// File: rtl/fault_classify.sv
module fault_classify
  import fault_recorder_pkg::*;
(
  input  logic [2:0]      result_code,
  input  logic [2:0]      access_kind,
  input  logic            is_store,
  output fault_decision_t decision
);
  logic [STAT_W-1:0] store_mask;

  always_comb begin
    store_mask = '0;
    store_mask[STORE_BIT] = is_store;
  end

  always_comb begin
    decision.kind       = EXC_PROGRAM;
    decision.code       = PROG_INVALID;
    decision.status     = '0;
    decision.upd_status = 1'b0;
    decision.upd_addr   = 1'b1;
    if (access_kind == AK_FETCH) begin
      if (result_code >= RC_NOMATCH && result_code <= RC_DIRECT) begin
        decision.kind     = EXC_ISTORAGE;
        decision.upd_addr = 1'b0;
        case (result_code)
          RC_NOMATCH: decision.code = ISI_NOMATCH;
          RC_PROT:    decision.code = ISI_PROT;
          default:    decision.code = ISI_NOEXEC;
        endcase
      end
    end else if (access_kind <= AK_EXTCTL) begin
      case (result_code)
        RC_NOMATCH: begin
          decision.kind       = EXC_DSTORAGE;
          decision.code       = '0;
          decision.status     = DST_NOMATCH | store_mask;
          decision.upd_status = 1'b1;
        end
        RC_PROT: begin
          decision.kind       = EXC_DSTORAGE;
          decision.code       = '0;
          decision.status     = DST_PROT | store_mask;
          decision.upd_status = 1'b1;
        end
        RC_DIRECT: begin
          case (access_kind)
            AK_FP: begin
              decision.kind = EXC_ALIGN;
              decision.code = ALIGN_FP_SUB;
            end
            AK_RESV: begin
              decision.kind       = EXC_DSTORAGE;
              decision.code       = '0;
              decision.status     = DST_RESV | store_mask;
              decision.upd_status = 1'b1;
            end
            AK_EXTCTL: begin
              decision.kind       = EXC_DSTORAGE;
              decision.code       = '0;
              decision.status     = DST_EXTCTL | store_mask;
              decision.upd_status = 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import fault_recorder_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  fault_decision_t   decision,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              sw_we,
  input  logic              sw_sel,
  input  logic [STAT_W-1:0] sw_wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic [STAT_W-1:0] status_d;
  logic [ADDR_W-1:0] addr_d;
  logic              status_en;
  logic              addr_en;

  always_comb begin
    status_en = 1'b0;
    addr_en   = 1'b0;
    status_d  = status_q;
    addr_d    = addr_q;
    if (fault_valid) begin
      status_en = decision.upd_status;
      addr_en   = decision.upd_addr;
      status_d  = decision.status;
      addr_d    = fault_addr;
    end else if (sw_we) begin
      status_en = !sw_sel;
      addr_en   = sw_sel;
      status_d  = sw_wdata;
      addr_d    = sw_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/fault_recorder.sv
module fault_recorder
  import fault_recorder_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [2:0]        result_code,
  input  logic [2:0]        access_kind,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              sw_we,
  input  logic              sw_sel,
  input  logic [31:0]       sw_wdata,
  output logic              exc_req,
  output logic [1:0]        exc_type,
  output logic [31:0]       err_code,
  output logic [31:0]       fault_status,
  output logic [ADDR_W-1:0] fault_addr_q
);
  fault_decision_t   decision;
  logic              req_d;
  logic [1:0]        type_d;
  logic [STAT_W-1:0] code_d;

  fault_classify u_classify (
    .result_code (result_code),
    .access_kind (access_kind),
    .is_store    (is_store),
    .decision    (decision)
  );

  fault_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_valid (fault_valid),
    .decision    (decision),
    .fault_addr  (fault_addr),
    .sw_we       (sw_we),
    .sw_sel      (sw_sel),
    .sw_wdata    (sw_wdata),
    .status_q    (fault_status),
    .addr_q      (fault_addr_q)
  );

  always_comb begin
    req_d  = fault_valid;
    type_d = exc_type;
    code_d = err_code;
    if (fault_valid) begin
      type_d = decision.kind;
      code_d = decision.code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req <= 1'b0;
    end else begin
      exc_req <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_type <= '0;
      err_code <= '0;
    end else if (fault_valid) begin
      exc_type <= type_d;
      err_code <= code_d;
    end
  end
endmodule

// File: rtl/fault_recorder_chk.sv
module fault_recorder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault_valid,
  input logic [2:0]        result_code,
  input logic [2:0]        access_kind,
  input logic              is_store,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              sw_we,
  input logic              exc_req,
  input logic [1:0]        exc_type,
  input logic [31:0]       err_code,
  input logic [31:0]       fault_status,
  input logic [ADDR_W-1:0] fault_addr_q
);
  a_r1_req_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> exc_req);
  a_r1_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> !exc_req);
  a_r2_fetch_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && access_kind == 3'd0 && result_code == 3'd1
    |=> exc_type == 2'd0 && err_code == 32'h4000_0000);
  a_r3_store_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && access_kind == 3'd1 && result_code == 3'd1 && is_store
    |=> exc_type == 2'd1 && fault_status == 32'h4200_0000);
  a_r7_fp_direct_align: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && access_kind == 3'd2 && result_code == 3'd4
    |=> exc_type == 2'd2 && $stable(fault_status));
  a_r8_data_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && access_kind != 3'd0 |=> fault_addr_q == $past(fault_addr));
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid && !sw_we |=> $stable(fault_status) && $stable(fault_addr_q));
endmodule

bind fault_recorder fault_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fault_valid  (fault_valid),
  .result_code  (result_code),
  .access_kind  (access_kind),
  .is_store     (is_store),
  .fault_addr   (fault_addr),
  .sw_we        (sw_we),
  .exc_req      (exc_req),
  .exc_type     (exc_type),
  .err_code     (err_code),
  .fault_status (fault_status),
  .fault_addr_q (fault_addr_q)
);

// File: tb/fault_recorder_tb.sv
module fault_recorder_tb;
  logic        clk;
  logic        rst_n;
  logic        fault_valid;
  logic [2:0]  result_code;
  logic [2:0]  access_kind;
  logic        is_store;
  logic [31:0] fault_addr;
  logic        sw_we;
  logic        sw_sel;
  logic [31:0] sw_wdata;
  logic        exc_req;
  logic [1:0]  exc_type;
  logic [31:0] err_code;
  logic [31:0] fault_status;
  logic [31:0] fault_addr_q;
  int checks;
  int errors;
  logic done;

  fault_recorder #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid),
    .result_code(result_code), .access_kind(access_kind), .is_store(is_store),
    .fault_addr(fault_addr), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .exc_req(exc_req), .exc_type(exc_type), .err_code(err_code),
    .fault_status(fault_status), .fault_addr_q(fault_addr_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0]  e_type;
    logic [31:0] e_code;
    logic [31:0] e_stat;
    logic [31:0] e_addr;
    logic [31:0] smark;
    logic [31:0] amark;
    logic [31:0] sbit;
    string       tag;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; fault_valid = 1'b0; result_code = '0; access_kind = '0;
    is_store = 1'b0; fault_addr = '0; sw_we = 1'b0; sw_sel = 1'b0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset req", {31'd0, exc_req}, 32'd0);
    chk("R10 reset type", {30'd0, exc_type}, 32'd0);
    chk("R10 reset code", err_code, 32'd0);
    chk("R10 reset status", fault_status, 32'd0);
    chk("R10 reset addr", fault_addr_q, 32'd0);

    for (int idx = 0; idx < 128; idx++) begin
      logic [2:0] rc;
      logic [2:0] ak;
      logic       st;
      rc = idx[6:4]; ak = idx[3:1]; st = idx[0];
      smark = 32'hA5A5_0000 ^ idx;
      amark = 32'h5A5A_0000 ^ idx;
      sw_write(1'b0, smark);
      sw_write(1'b1, amark);
      chk("R10 sw status write", fault_status, smark);
      chk("R10 sw addr write", fault_addr_q, amark);
      // expected model
      sbit = st ? 32'h0200_0000 : 32'h0;
      e_type = 2'd3; e_code = 32'h20; e_stat = smark;
      e_addr = 32'h1000_0000 + idx * 4;
      tag = "R9";
      if (ak == 3'd0) begin
        if (rc >= 3'd1 && rc <= 3'd4) begin
          tag = "R2"; e_type = 2'd0; e_addr = amark;
          e_code = (rc == 3'd1) ? 32'h4000_0000 :
                   (rc == 3'd2) ? 32'h0800_0000 : 32'h1000_0000;
        end
      end else if (ak <= 3'd4) begin
        if (rc == 3'd1) begin
          tag = "R3"; e_type = 2'd1; e_code = 0; e_stat = 32'h4000_0000 | sbit;
        end else if (rc == 3'd2) begin
          tag = "R4"; e_type = 2'd1; e_code = 0; e_stat = 32'h0800_0000 | sbit;
        end else if (rc == 3'd4 && ak == 3'd2) begin
          tag = "R7"; e_type = 2'd2; e_code = 32'h10;
        end else if (rc == 3'd4 && ak == 3'd3) begin
          tag = "R5"; e_type = 2'd1; e_code = 0; e_stat = 32'h0400_0000 | sbit;
        end else if (rc == 3'd4 && ak == 3'd4) begin
          tag = "R6"; e_type = 2'd1; e_code = 0; e_stat = 32'h0410_0000 | sbit;
        end
      end
      @(negedge clk);
      fault_valid = 1'b1; result_code = rc; access_kind = ak; is_store = st;
      fault_addr = 32'h1000_0000 + idx * 4;
      @(negedge clk);
      fault_valid = 1'b0; result_code = 3'd7; access_kind = 3'd7;
      fault_addr = 32'hFFFF_FFFF;
      chk("R1 req pulse high", {31'd0, exc_req}, 32'd1);
      chk({tag, " type"}, {30'd0, exc_type}, {30'd0, e_type});
      chk({tag, " code"}, err_code, e_code);
      chk({tag, " status"}, fault_status, e_stat);
      chk({tag, " R8 addr"}, fault_addr_q, e_addr);
      @(negedge clk);
      chk("R1 req pulse low", {31'd0, exc_req}, 32'd0);
      chk("R10 hold status", fault_status, e_stat);
      chk("R10 hold type", {30'd0, exc_type}, {30'd0, e_type});
    end

    // R10 fault beats simultaneous software write
    sw_write(1'b1, 32'h1234_5678);
    @(negedge clk);
    fault_valid = 1'b1; result_code = 3'd1; access_kind = 3'd1; is_store = 1'b0;
    fault_addr = 32'hCAFE_0000;
    sw_we = 1'b1; sw_sel = 1'b1; sw_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    fault_valid = 1'b0; sw_we = 1'b0;
    chk("R10 fault priority addr", fault_addr_q, 32'hCAFE_0000);
    chk("R3 load nomatch status", fault_status, 32'h4000_0000);

    // R1 back-to-back strobes
    @(negedge clk);
    fault_valid = 1'b1; result_code = 3'd2; access_kind = 3'd0;
    @(negedge clk);
    chk("R1 first pulse", {31'd0, exc_req}, 32'd1);
    result_code = 3'd1;
    @(negedge clk);
    fault_valid = 1'b0;
    chk("R1 second pulse", {31'd0, exc_req}, 32'd1);
    chk("R2 second code", err_code, 32'h4000_0000);
    @(negedge clk);
    chk("R1 pulse ends", {31'd0, exc_req}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule